// File: doc/BRIEF.md
# SPI Slave with Word Callbacks

This block is an SPI slave that runs entirely on the system clock. The serial clock, the master-to-slave data line and an active-high select are oversampled through synchronising flip-flops, their edges are found in the system clock domain, and the slave-to-master data line is driven from a shift register. It is used by local logic that behaves like a callback handler: the block asks for each transmit word with a one-cycle strobe, and the handler answers with a data/valid pair. The block then hands back each received word with the number of bits that are actually valid, and it signals the end of every transaction.

The word size (8 or 32 bits) and the clock mode (0 to 3) are fixed by parameters. A master that stops before a word is complete still produces a receive report, carrying the exact bit count. The transmit bits it did not clock out are dropped. If the handler is too slow to answer a request, zeros go out on the line and a sticky flag records the underrun.

Top module: `spi_cb_slave`

## Requirements
- R1: While select is low, activity on the serial clock and the input data line produces no receive report, no request strobe and no change to the word being assembled.
- R2: `tx_req_o` pulses for one cycle when select rises, and again each time a transmit word is taken into the shifter (at the sample edge of that word's first bit), so a transaction of n bits gives 1 + ceil(n / WORD_BITS) requests.
- R3: Both directions are least-significant bit first: the k-th bit clocked in a word is bit k of that word.
- R4: After every WORD_BITS sampled bits, `rx_valid_o` pulses for one cycle with the received word on `rx_data_o` and `rx_bits_o` equal to WORD_BITS.
- R5: If select falls with 1 to WORD_BITS-1 bits of a word received, a report is delivered with `rx_bits_o` equal to that count, the received bits in the low positions and zeros above them.
- R6: Transmit bits not yet clocked out when select falls are discarded. The next transaction starts with the word supplied for its own first request.
- R7: `end_o` is a single-cycle pulse after select falls, issued one cycle after any partial-word report.
- R8: Mode encoding: 0 = clock idles low, data changes on rising edges and is sampled on falling edges. 1 = idles low, sampled on rising edges, first bit valid before the first edge. 2 = idles high, sampled on falling edges, first bit valid before the first edge. 3 = idles high, data changes on falling edges and is sampled on rising edges.
- R9: A word taken when no transmit data is held is sent as zeros and sets `underrun_o`. The flag stays set until select next rises.
- R10: `miso_o` is 0 while select is low, and every strobe and flag output is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| sel_i | input | 1 | Active-high select from the master |
| miso_o | output | 1 | Serial data to the master |
| tx_data_i | input | WORD_BITS | Transmit word answering a request |
| tx_valid_i | input | 1 | Qualifies tx_data_i for one cycle |
| tx_req_o | output | 1 | Request for the next transmit word |
| rx_data_o | output | WORD_BITS | Received word, LSB first on the line |
| rx_bits_o | output | $clog2(WORD_BITS+1) | Valid bit count of rx_data_o |
| rx_valid_o | output | 1 | Receive report strobe |
| end_o | output | 1 | End-of-transaction strobe |
| underrun_o | output | 1 | Sticky transmit underrun flag |

## Verification
A wrong bit counter shows up at the first word boundary: the report arrives early or late, and its count no longer matches the number of edges the master generated. A stale shift register or holding register corrupts the data line for the rest of that word, and the master sees this at its very next sample. A transmit word that is not discarded at deselect only shows in the first bits of the following transaction. The bench therefore follows a short transaction with a full one and compares every sampled bit against the word supplied for each request.

// File: rtl/spi_cb_pkg.sv
package spi_cb_pkg;

  typedef struct packed {
    logic sample;
    logic drive;
  } sclk_evt_t;

  function automatic logic mode_idle_high(int mode);
    return (mode == 2) || (mode == 3);
  endfunction

  // modes 1 and 2 take data on the leading edge
  function automatic logic mode_sample_lead(int mode);
    return (mode == 1) || (mode == 2);
  endfunction

endpackage

// File: rtl/spi_cb_sync.sv
module spi_cb_sync
  import spi_cb_pkg::*;
#(
  parameter int MODE   = 0,
  parameter int STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sclk_i,
  input  logic      mosi_i,
  input  logic      sel_i,
  output sclk_evt_t evt_o,
  output logic      mosi_o,
  output logic      sel_o,
  output logic      sel_rise_o,
  output logic      sel_fall_o
);
  localparam int  CW        = 3 * STAGES;
  localparam logic IDLE_HI  = mode_idle_high(MODE);
  localparam logic SMP_LEAD = mode_sample_lead(MODE);

  logic [CW-1:0] chain;
  logic          sclk_q, sel_q;
  logic          sclk_s, mosi_s, sel_s;
  logic          rise, fall, lead, trail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain  <= '0;
      sclk_q <= IDLE_HI;
      sel_q  <= 1'b0;
    end else begin
      chain  <= {chain[CW-4:0], sel_i, mosi_i, sclk_i};
      sclk_q <= sclk_s;
      sel_q  <= sel_s;
    end
  end

  assign sclk_s = chain[CW-3];
  assign mosi_s = chain[CW-2];
  assign sel_s  = chain[CW-1];

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  if (IDLE_HI) begin : g_idle_hi
    assign lead  = fall;
    assign trail = rise;
  end else begin : g_idle_lo
    assign lead  = rise;
    assign trail = fall;
  end

  if (SMP_LEAD) begin : g_smp_lead
    assign evt_o.sample = sel_s & lead;
    assign evt_o.drive  = sel_s & trail;
  end else begin : g_smp_trail
    assign evt_o.sample = sel_s & trail;
    assign evt_o.drive  = sel_s & lead;
  end

  assign mosi_o     = mosi_s;
  assign sel_o      = sel_s;
  assign sel_rise_o = sel_s & ~sel_q;
  assign sel_fall_o = ~sel_s & sel_q;

endmodule

// File: rtl/spi_cb_rx.sv
module spi_cb_rx
  import spi_cb_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W),
  parameter int BW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sclk_evt_t     evt_i,
  input  logic          mosi_i,
  input  logic          sel_i,
  input  logic          sel_rise_i,
  input  logic          sel_fall_i,
  output logic          last_bit_o,
  output logic [W-1:0]  rx_data_o,
  output logic [BW-1:0] rx_bits_o,
  output logic          rx_valid_o,
  output logic          end_o
);
  logic [W-1:0]  acc, acc_nxt;
  logic [CW-1:0] cnt;
  logic          fall_d;

  assign acc_nxt    = acc | (W'(mosi_i) << cnt);
  assign last_bit_o = evt_i.sample && (cnt == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc        <= '0;
      cnt        <= '0;
      rx_data_o  <= '0;
      rx_bits_o  <= '0;
      rx_valid_o <= 1'b0;
      fall_d     <= 1'b0;
      end_o      <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      fall_d     <= sel_fall_i;
      end_o      <= fall_d;
      if (sel_rise_i) begin
        acc <= '0;
        cnt <= '0;
      end else if (sel_fall_i) begin
        if (cnt != '0) begin
          rx_data_o  <= acc;
          rx_bits_o  <= BW'(cnt);
          rx_valid_o <= 1'b1;
        end
        acc <= '0;
        cnt <= '0;
      end else if (evt_i.sample) begin
        if (last_bit_o) begin
          rx_data_o  <= acc_nxt;
          rx_bits_o  <= BW'(W);
          rx_valid_o <= 1'b1;
          acc        <= '0;
          cnt        <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_RX_BITS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_bits_o != '0) && (rx_bits_o <= BW'(W))); // R5
  AST_RX_FULL_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_bits_o == BW'(W)) |-> $past(sel_i)); // R1
  AST_END_AFTER_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !$past(sel_i, 2)); // R7
  AST_END_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o); // R7

endmodule

// File: rtl/spi_cb_tx.sv
module spi_cb_tx
  import spi_cb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sclk_evt_t    evt_i,
  input  logic         last_bit_i,
  input  logic         sel_i,
  input  logic         sel_rise_i,
  input  logic         sel_fall_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         miso_o,
  output logic         tx_req_o,
  output logic         underrun_o
);
  logic [W-1:0] hold, shreg;
  logic         hold_v, loaded, take;

  // a word is taken at the sample edge of its first bit
  assign take = evt_i.sample & ~loaded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold       <= '0;
      hold_v     <= 1'b0;
      shreg      <= '0;
      loaded     <= 1'b0;
      tx_req_o   <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      tx_req_o <= sel_rise_i | take;
      if (tx_valid_i) begin
        hold   <= tx_data_i;
        hold_v <= 1'b1;
      end else if (take || sel_fall_i) begin
        hold_v <= 1'b0;
      end
      if (sel_rise_i) underrun_o <= 1'b0;
      else if (take && !hold_v) underrun_o <= 1'b1;
      if (sel_fall_i) begin
        shreg  <= '0;
        loaded <= 1'b0;
      end else if (take) begin
        shreg  <= hold_v ? hold : '0;
        loaded <= !last_bit_i;
      end else begin
        if (evt_i.drive && loaded) shreg <= shreg >> 1;
        if (last_bit_i) loaded <= 1'b0;
      end
    end
  end

  assign miso_o = sel_i & (loaded ? shreg[0] : (hold_v & hold[0]));

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |=> !tx_req_o); // R2
  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !sel_rise_i) |=> underrun_o); // R9
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(evt_i.sample)); // R9

endmodule

// File: rtl/spi_cb_slave.sv
module spi_cb_slave
  import spi_cb_pkg::*;
#(
  parameter int WORD_BITS   = 8,
  parameter int MODE        = 0,
  parameter int SYNC_STAGES = 2,
  localparam int BW         = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 mosi_i,
  input  logic                 sel_i,
  output logic                 miso_o,
  input  logic [WORD_BITS-1:0] tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_req_o,
  output logic [WORD_BITS-1:0] rx_data_o,
  output logic [BW-1:0]        rx_bits_o,
  output logic                 rx_valid_o,
  output logic                 end_o,
  output logic                 underrun_o
);
  sclk_evt_t evt;
  logic      mosi_s, sel_s, sel_rise, sel_fall, last_bit;

  spi_cb_sync #(.MODE(MODE), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .mosi_i     (mosi_i),
    .sel_i      (sel_i),
    .evt_o      (evt),
    .mosi_o     (mosi_s),
    .sel_o      (sel_s),
    .sel_rise_o (sel_rise),
    .sel_fall_o (sel_fall)
  );

  spi_cb_rx #(.W(WORD_BITS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .mosi_i     (mosi_s),
    .sel_i      (sel_s),
    .sel_rise_i (sel_rise),
    .sel_fall_i (sel_fall),
    .last_bit_o (last_bit),
    .rx_data_o  (rx_data_o),
    .rx_bits_o  (rx_bits_o),
    .rx_valid_o (rx_valid_o),
    .end_o      (end_o)
  );

  spi_cb_tx #(.W(WORD_BITS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .last_bit_i (last_bit),
    .sel_i      (sel_s),
    .sel_rise_i (sel_rise),
    .sel_fall_i (sel_fall),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .miso_o     (miso_o),
    .tx_req_o   (tx_req_o),
    .underrun_o (underrun_o)
  );

  AST_NO_DATA_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !rx_valid_o); // R7

endmodule

// File: tb/tb_spi_cb_slave.sv
module tb_spi_cb_slave;
  localparam int NI = 5;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          sclk = 1'b0, mosi = 1'b0;
  logic [NI-1:0] sel_v = '0, supply_en = '1;
  logic [NI-1:0] miso_v, req_v, rxv_v, end_v, unr_v;
  logic [NI-1:0] txv_v = '0;
  logic [31:0]   txd_a [NI];
  logic [31:0]   rxd_a [NI];
  int            rxb_a [NI];

  int            req_n [NI];
  int            ev_n  [NI];
  logic [31:0]   ev_d  [NI][64];
  int            ev_b  [NI][64];
  int            n_cmp = 0, n_bad = 0;

  for (genvar k = 0; k < NI; k++) begin : g_inst
    localparam int W = (k == 4) ? 32 : 8;
    localparam int M = (k == 4) ? 1 : k;
    logic [W-1:0]             rxd;
    logic [$clog2(W+1)-1:0]   rxb;
    assign rxd_a[k] = 32'(rxd);
    assign rxb_a[k] = int'(rxb);
    if (k == 4) begin : g_wide
      spi_cb_slave #(.WORD_BITS(W), .MODE(M)) dut (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .sel_i(sel_v[k]),
        .miso_o(miso_v[k]), .tx_data_i(txd_a[k][W-1:0]), .tx_valid_i(txv_v[k]),
        .tx_req_o(req_v[k]), .rx_data_o(rxd), .rx_bits_o(rxb), .rx_valid_o(rxv_v[k]),
        .end_o(end_v[k]), .underrun_o(unr_v[k]));
    end else begin : g_byte
      spi_cb_slave #(.WORD_BITS(W), .MODE(M)) dut_m (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .sel_i(sel_v[k]),
        .miso_o(miso_v[k]), .tx_data_i(txd_a[k][W-1:0]), .tx_valid_i(txv_v[k]),
        .tx_req_o(req_v[k]), .rx_data_o(rxd), .rx_bits_o(rxb), .rx_valid_o(rxv_v[k]),
        .end_o(end_v[k]), .underrun_o(unr_v[k]));
    end
  end

  function automatic logic [31:0] pat(int k, int r);
    return 32'h3C5A_96E1 ^ (32'(r) * 32'h9E37_79B9) ^ (32'(k) << 24);
  endfunction

  function automatic int wbits(int k);
    return (k == 4) ? 32 : 8;
  endfunction

  function automatic int bmode(int k);
    return (k == 4) ? 1 : k;
  endfunction

  // handler model and event log, all on the falling clock edge
  initial begin
    for (int k = 0; k < NI; k++) begin
      req_n[k] = 0;
      ev_n[k]  = 0;
      txd_a[k] = '0;
    end
  end

  always @(negedge clk) begin
    for (int k = 0; k < NI; k++) begin
      if (req_v[k]) begin
        txd_a[k] <= pat(k, req_n[k]);
        txv_v[k] <= supply_en[k];
        req_n[k] = req_n[k] + 1;
      end else begin
        txv_v[k] <= 1'b0;
      end
      if (rxv_v[k] && ev_n[k] < 64) begin
        ev_d[k][ev_n[k]] = rxd_a[k];
        ev_b[k][ev_n[k]] = rxb_a[k];
        ev_n[k] = ev_n[k] + 1;
      end
      if (end_v[k] && ev_n[k] < 64) begin
        ev_d[k][ev_n[k]] = '0;
        ev_b[k][ev_n[k]] = -1;
        ev_n[k] = ev_n[k] + 1;
      end
    end
  end

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // master model: shared clock and data, one select per instance
  task automatic xfer(int k, int n, logic [63:0] m, output logic [63:0] mi);
    int  md   = bmode(k);
    bit  cpol = (md >= 2);
    bit  cpha = (md == 0) || (md == 3);
    mi   = '0;
    sclk = cpol;
    mosi = cpha ? 1'b0 : m[0];
    wait_clk(4);
    sel_v[k] = 1'b1;
    wait_clk(12);
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        mi[i] = miso_v[k];
        sclk  = ~cpol;
        wait_clk(H);
        sclk  = cpol;
        mosi  = (i + 1 < n) ? m[i+1] : 1'b0;
        wait_clk(H);
      end else begin
        sclk = ~cpol;
        mosi = m[i];
        wait_clk(H);
        mi[i] = miso_v[k];
        sclk  = cpol;
        wait_clk(H);
      end
    end
    wait_clk(H);
    sel_v[k] = 1'b0;
    wait_clk(12);
    mosi = 1'b0;
  endtask

  task automatic transact(int k, int n, logic [63:0] m, bit supply,
                          string rq_tx, string rq_rx);
    int          w  = wbits(k);
    int          r0 = req_n[k];
    int          e0 = ev_n[k];
    int          nf = n / w;
    int          np = n % w;
    logic [63:0] mi, exp_mi;
    logic [31:0] wd;
    supply_en[k] = supply;
    xfer(k, n, m, mi);
    exp_mi = '0;
    for (int i = 0; i < n; i++) begin
      wd = supply ? pat(k, r0 + i / w) : 32'h0;
      exp_mi[i] = wd[i % w];
    end
    chk(rq_tx, "miso bits", mi, exp_mi);
    chk("R2", "request count", 64'(req_n[k] - r0), 64'(1 + (n + w - 1) / w));
    chk(rq_rx, "report count", 64'(ev_n[k] - e0), 64'(nf + (np != 0 ? 1 : 0) + 1));
    for (int j = 0; j < nf; j++) begin
      chk("R4", "full word", 64'(ev_d[k][e0+j]), (m >> (j * w)) & ((64'd1 << w) - 1));
      chk("R4", "full count", 64'(ev_b[k][e0+j]), 64'(w));
    end
    if (np != 0) begin
      chk("R5", "partial word", 64'(ev_d[k][e0+nf]), (m >> (nf * w)) & ((64'd1 << np) - 1));
      chk("R5", "partial count", 64'(ev_b[k][e0+nf]), 64'(np));
    end
    chk("R7", "end strobe last", 64'(ev_b[k][e0+nf+(np != 0 ? 1 : 0)]), 64'(-1));
    supply_en[k] = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10", "miso after reset", 64'(miso_v), 64'h0);
    chk("R10", "req after reset", 64'(req_v), 64'h0);
    chk("R10", "rx_valid after reset", 64'(rxv_v), 64'h0);
    chk("R10", "end after reset", 64'(end_v), 64'h0);
    chk("R10", "underrun after reset", 64'(unr_v), 64'h0);
  endtask

  task automatic t_byte_stream();
    transact(0, 16, 64'hB4E1, 1'b1, "R3", "R4");
  endtask

  task automatic t_modes();
    transact(1, 8, 64'h6D, 1'b1, "R8", "R8");
    transact(2, 8, 64'h92, 1'b1, "R8", "R8");
    transact(3, 16, 64'h35CA, 1'b1, "R8", "R8");
  endtask

  task automatic t_partial_byte();
    transact(0, 11, 64'h5A3, 1'b1, "R3", "R5");
  endtask

  task automatic t_wide();
    transact(4, 64, 64'hF00D_1234_8BAD_C0DE, 1'b1, "R3", "R4");
    transact(4, 13, 64'h1A5B, 1'b1, "R3", "R5");
  endtask

  task automatic t_discard();
    transact(2, 5, 64'h15, 1'b1, "R6", "R5");
    transact(2, 8, 64'hC3, 1'b1, "R6", "R6");
  endtask

  task automatic t_ignore();
    int          r0 = req_n[0];
    int          e0 = ev_n[0];
    logic [63:0] mi;
    sclk = 1'b0;
    for (int i = 0; i < 10; i++) begin
      mosi = i[0];
      sclk = ~sclk;
      wait_clk(H);
      chk("R10", "miso deselected", 64'(miso_v), 64'h0);
    end
    sclk = 1'b0;
    wait_clk(10);
    chk("R1", "no reports while deselected", 64'(ev_n[0] - e0), 64'h0);
    chk("R1", "no requests while deselected", 64'(req_n[0] - r0), 64'h0);
    // a following transaction must see a clean word assembly
    transact(0, 8, 64'h4E, 1'b1, "R1", "R1");
    mi = '0;
  endtask

  task automatic t_underrun();
    transact(1, 8, 64'hA7, 1'b0, "R9", "R4");
    chk("R9", "underrun flag set", 64'(unr_v[1]), 64'h1);
    wait_clk(20);
    chk("R9", "underrun flag sticky", 64'(unr_v[1]), 64'h1);
    transact(1, 8, 64'h3B, 1'b1, "R9", "R4");
    chk("R9", "underrun cleared", 64'(unr_v[1]), 64'h0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_byte_stream();
    t_modes();
    t_partial_byte();
    t_wide();
    t_discard();
    t_ignore();
    t_underrun();
    wait_clk(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule